// File: doc/BRIEF.md
# Phase-Programmable Channel Clock Divider

One output channel of a clock distribution tree. The block takes a programmable integer ratio and divides a source clock by it. After a synchronization event it delays the first output edge by a programmable number of half source periods. It can then invert the divided clock, and it steers the result onto a two-pin output. For each pin, a 4-bit drive-mode code selects the true phase, the complement phase or high-Z.

The block runs on `clk`, which runs at twice the source frequency, so one `clk` cycle equals one half source period. All configuration fields are static while the channel runs; change them only while the channel is held by sync or power-down. The block produces only the logical pin values and their enables.

A pin that is not enabled, or a powered-down channel, drives value 0 with its enable low.

Top module: `chan_clk_div`

## Requirements
- R1: With divide field D, the divided clock is periodic with a period of 2(D+1) `clk` cycles. It is high for D+1 cycles and then low for D+1 cycles, starting high in the first running cycle.
- R2: With D = 0 the divided clock toggles on every `clk` edge, so it follows the source clock.
- R3: With phase field P and sync released, take the first rising edge at which sync is sampled low. The divided clock stays low until P further edges have passed, and goes high right after edge P counted from that first edge.
- R4: While `sync_i` is high and `cfg_ign_sync_i` is 0, the divided clock is low one edge later. Counting restarts per R3 when sync is released.
- R5: When `cfg_ign_sync_i` is 1, `sync_i` has no effect on the pins.
- R6: When `cfg_invert_i` is 1, every driven pin carries the inverse of what it would carry with the bit at 0.
- R7: When `cfg_pd_i` is 1, both pin enables and both pin values are 0 and the divider is held. Leaving power-down restarts the divider exactly like a sync release (R3).
- R8: Mode codes 4'b0000, 4'b1111 and 4'b1010 leave both pins disabled.
- R9: Mode 4'b0110 drives both pins true, 4'b1011 drives both complement, 4'b0111 drives + true and − complement, and 4'b1100 drives + complement and − true.
- R10: Mode 4'b1000 drives + true with − off, 4'b1001 drives − true with + off, 4'b1101 drives + complement with − off, and 4'b1110 drives − complement with + off.
- R11: Mode codes 4'b0001 to 4'b0101 drive + true and − complement.
- R12: In reset the divided clock is low. After reset is released with sync low, it starts high after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the source frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Chip-level synchronization, active high |
| cfg_div_i | input | DIV_W | Divide field; ratio is field + 1 |
| cfg_phase_i | input | PH_W | Start delay after sync in half source periods |
| cfg_invert_i | input | 1 | Invert divided clock |
| cfg_ign_sync_i | input | 1 | Disregard sync when 1 |
| cfg_pd_i | input | 1 | Power down the channel |
| cfg_mode_i | input | 4 | Pin drive-mode code |
| pos_o | output | 1 | + pin value |
| pos_oe_o | output | 1 | + pin enable |
| neg_o | output | 1 | − pin value |
| neg_oe_o | output | 1 | − pin enable |

## Verification
The hardest case to reach is the alignment of the first edge after a hold ends. Sync release and power-down release must both give exactly P low cycles, and the next full period must follow. Nothing at the ports shows how far the hidden delay count has progressed. The stimulus therefore holds the channel, changes ratio and phase, releases it, and compares every following cycle against a reference timeline. That timeline is rebuilt from the release edge, with large phase values, ratio 1024 and random ratios.

// File: rtl/chan_clk_div_pkg.sv
package chan_clk_div_pkg;
    typedef enum logic [1:0] {
        SEL_OFF  = 2'd0,
        SEL_TRUE = 2'd1,
        SEL_COMP = 2'd2
    } pin_sel_e;
endpackage

// File: rtl/chdiv_counter.sv
module chdiv_counter #(
    parameter int DIV_W = 10,
    parameter int PH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic             clk_div_o,
    output logic             run_o
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic             run;
        logic [PH_W-1:0]  dly;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] last_cnt;

    assign half_len = CNT_W'(div_i) + CNT_W'(1);
    assign last_cnt = {div_i, 1'b1};

    always_comb begin
        s_d = s_q;
        if (hold_i) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
            s_d.dly = phase_i;
        end else if (!s_q.run) begin
            if (s_q.dly == '0) begin
                s_d.run = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.dly = s_q.dly - PH_W'(1);
            end
        end else if (s_q.cnt == last_cnt) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_div_o = s_q.run && (s_q.cnt < half_len);
    assign run_o     = s_q.run;
endmodule

// File: rtl/chdiv_pin_map.sv
module chdiv_pin_map
    import chan_clk_div_pkg::*;
(
    input  logic [3:0] mode_i,
    input  logic       clk_i,
    input  logic       enable_i,
    output logic       pos_o,
    output logic       pos_oe_o,
    output logic       neg_o,
    output logic       neg_oe_o
);
    pin_sel_e pos_sel, neg_sel;

    always_comb begin
        pos_sel = SEL_OFF;
        neg_sel = SEL_OFF;
        unique case (mode_i)
            4'b0110: begin pos_sel = SEL_TRUE; neg_sel = SEL_TRUE; end
            4'b1000: begin pos_sel = SEL_TRUE; end
            4'b1001: begin neg_sel = SEL_TRUE; end
            4'b1011: begin pos_sel = SEL_COMP; neg_sel = SEL_COMP; end
            4'b1100: begin pos_sel = SEL_COMP; neg_sel = SEL_TRUE; end
            4'b1101: begin pos_sel = SEL_COMP; end
            4'b1110: begin neg_sel = SEL_COMP; end
            4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111: begin
                pos_sel = SEL_TRUE;
                neg_sel = SEL_COMP;
            end
            default: begin pos_sel = SEL_OFF; neg_sel = SEL_OFF; end
        endcase
    end

    function automatic logic pin_val(input pin_sel_e sel, input logic c);
        return (sel == SEL_TRUE) ? c : ((sel == SEL_COMP) ? ~c : 1'b0);
    endfunction

    assign pos_oe_o = enable_i && (pos_sel != SEL_OFF);
    assign neg_oe_o = enable_i && (neg_sel != SEL_OFF);
    assign pos_o    = enable_i && pin_val(pos_sel, clk_i);
    assign neg_o    = enable_i && pin_val(neg_sel, clk_i);
endmodule

// File: rtl/chan_clk_div.sv
module chan_clk_div #(
    parameter int DIV_W = 10,
    parameter int PH_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic [PH_W-1:0]  cfg_phase_i,
    input  logic             cfg_invert_i,
    input  logic             cfg_ign_sync_i,
    input  logic             cfg_pd_i,
    input  logic [3:0]       cfg_mode_i,
    output logic             pos_o,
    output logic             pos_oe_o,
    output logic             neg_o,
    output logic             neg_oe_o
);
    logic hold;
    logic div_clk;
    logic div_run;

    assign hold = cfg_pd_i || (sync_i && !cfg_ign_sync_i);

    chdiv_counter #(.DIV_W(DIV_W), .PH_W(PH_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (hold),
        .div_i     (cfg_div_i),
        .phase_i   (cfg_phase_i),
        .clk_div_o (div_clk),
        .run_o     (div_run)
    );

    chdiv_pin_map u_map (
        .mode_i   (cfg_mode_i),
        .clk_i    (div_clk ^ cfg_invert_i),
        .enable_i (!cfg_pd_i),
        .pos_o    (pos_o),
        .pos_oe_o (pos_oe_o),
        .neg_o    (neg_o),
        .neg_oe_o (neg_oe_o)
    );
endmodule

// File: rtl/chan_clk_div_chk.sv
module chan_clk_div_chk #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_i,
    input logic [DIV_W-1:0] cfg_div_i,
    input logic             cfg_ign_sync_i,
    input logic             cfg_pd_i,
    input logic [3:0]       cfg_mode_i,
    input logic             pos_o,
    input logic             pos_oe_o,
    input logic             neg_o,
    input logic             neg_oe_o,
    input logic             div_clk,
    input logic             div_run
);
    p_div1_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_run && $past(div_run) && cfg_div_i == '0 && $past(cfg_div_i) == '0)
        |-> (div_clk != $past(div_clk)));

    p_sync_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !cfg_ign_sync_i) |=> !div_clk);

    p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pd_i |=> !div_run);

    p_pd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pd_i |-> (!pos_oe_o && !neg_oe_o && !pos_o && !neg_o));

    p_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i == 4'b0000 || cfg_mode_i == 4'b1111) |-> (!pos_oe_o && !neg_oe_o));

    p_opposite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pd_i && cfg_mode_i == 4'b0111) |-> (pos_oe_o && neg_oe_o && pos_o != neg_o));
endmodule

bind chan_clk_div chan_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_i         (sync_i),
    .cfg_div_i      (cfg_div_i),
    .cfg_ign_sync_i (cfg_ign_sync_i),
    .cfg_pd_i       (cfg_pd_i),
    .cfg_mode_i     (cfg_mode_i),
    .pos_o          (pos_o),
    .pos_oe_o       (pos_oe_o),
    .neg_o          (neg_o),
    .neg_oe_o       (neg_oe_o),
    .div_clk        (div_clk),
    .div_run        (div_run)
);

// File: tb/chan_clk_div_tb.sv
`timescale 1ns/1ps
module chan_clk_div_tb;
    localparam int DIV_W = 10;
    localparam int PH_W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [PH_W-1:0] phase = '0;
    logic inv = 1'b0;
    logic ign = 1'b0;
    logic pd = 1'b0;
    logic [3:0] mode = 4'b0111;
    logic pos_o, pos_oe, neg_o, neg_oe;

    int checks = 0;
    int errors = 0;

    bit m_held = 1'b1;
    int m_wait = 0;
    int m_start = 0;
    int edge_n = 0;

    always #2.5 clk = ~clk;

    chan_clk_div #(.DIV_W(DIV_W), .PH_W(PH_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync), .cfg_div_i(div),
        .cfg_phase_i(phase), .cfg_invert_i(inv), .cfg_ign_sync_i(ign),
        .cfg_pd_i(pd), .cfg_mode_i(mode),
        .pos_o(pos_o), .pos_oe_o(pos_oe), .neg_o(neg_o), .neg_oe_o(neg_oe)
    );

    // pin selection per mode: 0 off, 1 true, 2 complement
    function automatic int sel_pos(input logic [3:0] m);
        case (m)
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: return 1;
            4'd11, 4'd12, 4'd13: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int sel_neg(input logic [3:0] m);
        case (m)
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd14, 4'd11: return 2;
            4'd6, 4'd9, 4'd12: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] pin_exp(input int sel, input logic c, input logic off);
        if (off || sel == 0) return 2'b00;
        return {1'b1, (sel == 1) ? c : ~c};
    endfunction

    function automatic logic exp_div();
        int n;
        if (m_held) return 1'b0;
        n = int'(div) + 1;
        return (((edge_n - m_start) % (2 * n)) < n);
    endfunction

    function automatic string mode_tag(input logic [3:0] m);
        if (m == 4'd0 || m == 4'd15 || m == 4'd10) return "R8";
        if (m == 4'd6 || m == 4'd7 || m == 4'd11 || m == 4'd12) return "R9";
        if (m == 4'd8 || m == 4'd9 || m == 4'd13 || m == 4'd14) return "R10";
        return "R11";
    endfunction

    task automatic step(input string tag);
        logic c;
        logic [3:0] exp, act;
        @(posedge clk);
        edge_n++;
        if (!rst_n) begin
            m_held = 1'b1; m_wait = 0;
        end else if (pd || (sync && !ign)) begin
            m_held = 1'b1; m_wait = int'(phase);
        end else if (m_held) begin
            if (m_wait == 0) begin m_held = 1'b0; m_start = edge_n; end
            else m_wait--;
        end
        #1;
        c = exp_div() ^ inv;
        exp = {pin_exp(sel_pos(mode), c, pd), pin_exp(sel_neg(mode), c, pd)};
        act = {pos_oe, pos_o, neg_oe, neg_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b (mode %b div %0d ph %0d)",
                     tag, edge_n, act, exp, mode, div, phase);
        end
    endtask

    task automatic seg(input int dv, input int ph, input bit iv, input logic [3:0] md,
                       input bit ig, input int nrun, input string tag);
        sync = 1'b1; ign = 1'b0; pd = 1'b0;
        div = DIV_W'(dv); phase = PH_W'(ph); inv = iv; mode = md;
        repeat (3) step(tag);
        ign = ig; sync = 1'b0;
        repeat (nrun) step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual still running, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R12: reset state, then start
        repeat (3) step("R12");
        rst_n = 1'b1;
        repeat (6) step("R12");

        seg(0, 0, 0, 4'b0111, 0, 12, "R2");
        seg(3, 0, 0, 4'b0111, 0, 30, "R1");
        seg(4, 0, 0, 4'b1000, 0, 30, "R1");
        seg(2, 5, 0, 4'b0111, 0, 25, "R3");
        seg(0, 63, 0, 4'b0110, 0, 80, "R3");
        seg(1023, 2, 0, 4'b0111, 0, 4200, "R1");
        seg(5, 3, 1, 4'b0111, 0, 30, "R6");
        seg(0, 1, 1, 4'b1011, 0, 10, "R6");

        // R4: sync mid-run holds the clock low
        seg(3, 0, 0, 4'b0111, 0, 11, "R4");
        sync = 1'b1; repeat (5) step("R4");
        sync = 1'b0; repeat (20) step("R4");

        // R5: sync ignored while running
        seg(2, 4, 0, 4'b0111, 1, 13, "R5");
        sync = 1'b1; repeat (9) step("R5");
        sync = 1'b0; repeat (9) step("R5");
        ign = 1'b0;

        // R7: power-down and restart
        seg(3, 7, 0, 4'b0110, 0, 15, "R7");
        pd = 1'b1; repeat (6) step("R7");
        pd = 1'b0; repeat (25) step("R7");

        // every mode code
        for (int m = 0; m < 16; m++) begin
            seg(1, 0, m[0], 4'(m), 0, 8, mode_tag(4'(m)));
        end

        // random segments
        for (int i = 0; i < 40; i++) begin
            int dv, ph, r;
            r  = int'($urandom % 16);
            dv = (r == 0) ? 1023 - int'($urandom % 4) : int'($urandom % 14);
            ph = int'($urandom % 64);
            seg(dv, ph, bit'($urandom % 2), 4'($urandom % 16), 0,
                (dv > 100) ? 2200 : 40 + int'($urandom % 40), "R1");
            if ($urandom % 4 == 0) begin
                pd = 1'b1; repeat (3) step("R7");
                pd = 1'b0; repeat (70) step("R7");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule